// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Watchdog

This block is a 16-bit down-counter behind a small register bus. A 4-bit prescale code sets how many clock cycles make one count tick. A 2-bit mode field sets what happens when the count is at zero on a tick. In free-running mode the count wraps to 0xFFFF and an interrupt pulse is raised. In periodic mode the count reloads from the load register and an interrupt pulse is raised. In one-shot mode a single interrupt pulse is raised and the counter halts. In watchdog mode a system-reset request is raised for a fixed number of cycles. Any write to the load register restarts the count from the written value, so in watchdog mode that write is the keep-alive.

Software programs the load value, then sets the enable bit in the control register. Setting enable copies the load register into the counter. While enable is clear the counter holds its value and produces no events. A separate cause flag records that a watchdog expiry occurred. The flag and the reset-request generator sit on the power-on reset `por_n`, so they survive the system reset `rst_n` that the request triggers. Software clears the flag by writing 1 to its bit.

The count sequencer has three states. CS_IDLE (disabled, holding) moves to CS_RUN when enable is seen, loading the counter. CS_RUN returns to CS_IDLE when enable is cleared, and moves to CS_HALT on a one-shot or watchdog expiry. CS_HALT returns to CS_IDLE when enable is cleared, and returns to CS_RUN on a load-register write. The request generator moves from RQ_IDLE to RQ_HOLD on a watchdog expiry and returns to RQ_IDLE after its hold time.

Top module: `mode_timer_wdog`

## Requirements
- R1: After reset the bus reads return 0 at all three addresses, and `irq_pulse` and `sys_rst_req` are low. The load/count register is at byte address 0x0, the control register is at 0x8, and the status register is at 0xC.
- R2: A read of the control register (0x8) returns bits [7:0] of the last write to it, with bits [31:8] reading 0. In the control register, bit 7 is enable, bit 6 is spare, bits [5:4] are the mode (0 free-running, 1 periodic, 2 one-shot, 3 watchdog) and bits [3:0] are the prescale code.
- R3: Prescale code n gives one count tick every 2^n cycles for n from 0 to 14; code 15 gives one tick every 65536 cycles. With load value L, the first expiry happens on the (L+1)th tick after the counter is armed.
- R4: While enable is clear the count (read at 0x0) holds, no interrupt or reset request occurs, and a write to the load register does not change the count.
- R5: The counter takes the load register value on the cycle after the write that sets enable.
- R6: In periodic mode each expiry reloads the counter and raises `irq_pulse` for one cycle, with a spacing of (L+1)·2^n cycles.
- R7: In one-shot mode an expiry raises `irq_pulse` once; the count then stays at 0 and no further pulse follows.
- R8: In free-running mode an expiry raises `irq_pulse` and the count becomes 0xFFFF.
- R9: A write to the load register while running restarts the count from the written value and clears the prescaler phase, so the next expiry comes (L+1)·2^n cycles after that write.
- R10: A watchdog expiry holds `sys_rst_req` high for exactly 16 consecutive cycles, and never raises `irq_pulse`.
- R11: A watchdog expiry sets status bit 1 (address 0xC). That bit survives `rst_n`, is unchanged by writing 0 to it, and is cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the cause flag and request generator |
| rst_n | input | 1 | System reset, active low; clears registers and counter |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| irq_pulse | output | 1 | One-cycle interrupt on expiry in non-watchdog modes |
| sys_rst_req | output | 1 | System-reset request after watchdog expiry |

## Verification
The checks assume that `por_n` is asserted once at start-up before `rst_n` matters, and that bus strobes change only away from the active clock edge. They also assume that a watchdog expiry cannot recur while a request is still being held. The one-cycle interrupt width is checked only when at least two ticks fall between expiries. For that reason, the stimulus table never pairs load 0 with prescale code 0 in periodic mode. The bench drives every input on the falling edge. It also re-arms the watchdog with keep-alive spacings shorter than the programmed interval, until it lets the watchdog expire on purpose.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

    localparam int CODE_W = 4;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2,
        MODE_WDOG     = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic              enable;
        logic              spare;
        tmr_mode_e         mode;
        logic [CODE_W-1:0] presc;
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_RUN  = 2'd1,
        CS_HALT = 2'd2
    } cnt_state_e;

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_HOLD = 1'b1
    } req_state_e;

    localparam logic [ADDR_W-1:0] ADDR_LOAD = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h8;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 4'hC;
    localparam int CAUSE_BIT = 1;

endpackage

// File: rtl/mtw_prescaler.sv
module mtw_prescaler #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int SHIFT_MAX = 1 << CODE_W;
    localparam int PRE_W     = SHIFT_MAX;
    localparam int SH_W      = $clog2(SHIFT_MAX + 1);

    logic [PRE_W-1:0] pre_q;
    logic [SH_W-1:0]  shift;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;
    logic             unused_top;

    // The top code stretches one step further than 2^code.
    always_comb begin
        if (code == {CODE_W{1'b1}}) begin
            shift = SH_W'(SHIFT_MAX);
        end else begin
            shift = SH_W'(code);
        end
        span = ((PRE_W + 1)'(1) << shift) - (PRE_W + 1)'(1);
        mask = span[PRE_W-1:0];
    end

    assign unused_top = span[PRE_W];
    assign tick       = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/mtw_count_core.sv
module mtw_count_core
    import mtw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  tmr_mode_e        mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] count,
    output logic             fire,
    output logic             pre_clr,
    output logic             run
);
    cnt_state_e       state_q, state_nxt;
    logic [CNT_W-1:0] count_q, count_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_nxt;
            count_q <= count_nxt;
        end
    end

    // Next state, counter update and strobes
    always_comb begin
        state_nxt = state_q;
        count_nxt = count_q;
        fire      = 1'b0;
        pre_clr   = 1'b0;
        run       = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                if (enable) begin
                    state_nxt = CS_RUN;
                    count_nxt = load_val;
                    pre_clr   = 1'b1;
                end
            end
            CS_RUN: begin
                if (!enable) begin
                    state_nxt = CS_IDLE;
                end else if (load_wr) begin
                    count_nxt = wr_val;
                    pre_clr   = 1'b1;
                end else begin
                    run = 1'b1;
                    if (tick) begin
                        if (count_q == '0) begin
                            fire = 1'b1;
                            case (mode)
                                MODE_FREE:     count_nxt = {CNT_W{1'b1}};
                                MODE_PERIODIC: count_nxt = load_val;
                                MODE_ONESHOT:  state_nxt = CS_HALT;
                                MODE_WDOG:     state_nxt = CS_HALT;
                                default:       state_nxt = CS_HALT;
                            endcase
                        end else begin
                            count_nxt = count_q - CNT_W'(1);
                        end
                    end
                end
            end
            CS_HALT: begin
                if (!enable) begin
                    state_nxt = CS_IDLE;
                end else if (load_wr) begin
                    state_nxt = CS_RUN;
                    count_nxt = wr_val;
                    pre_clr   = 1'b1;
                end
            end
            default: begin
                state_nxt = CS_IDLE;
            end
        endcase
    end

    assign count = count_q;
endmodule

// File: rtl/mtw_reset_pulse.sv
module mtw_reset_pulse
    import mtw_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic bite,
    input  logic flag_clr,
    output logic req,
    output logic cause_flag
);
    localparam int HC_W = $clog2(HOLD_CYC + 1);

    req_state_e      rq_q, rq_nxt;
    logic [HC_W-1:0] hold_q, hold_nxt;
    logic            flag_q;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rq_q   <= RQ_IDLE;
            hold_q <= '0;
        end else begin
            rq_q   <= rq_nxt;
            hold_q <= hold_nxt;
        end
    end

    always_comb begin
        rq_nxt   = rq_q;
        hold_nxt = hold_q;
        unique case (rq_q)
            RQ_IDLE: begin
                if (bite) begin
                    rq_nxt   = RQ_HOLD;
                    hold_nxt = HC_W'(HOLD_CYC - 1);
                end
            end
            RQ_HOLD: begin
                if (hold_q == '0) begin
                    rq_nxt = RQ_IDLE;
                end else begin
                    hold_nxt = hold_q - HC_W'(1);
                end
            end
            default: rq_nxt = RQ_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        req = (rq_q == RQ_HOLD);
    end

    // Sticky cause flag: a new expiry wins over a clear in the same cycle
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (bite) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign cause_flag = flag_q;
endmodule

// File: rtl/mode_timer_wdog.sv
module mode_timer_wdog
    import mtw_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int HOLD_CYC = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_pulse,
    output logic              sys_rst_req
);
    localparam int CTRL_W = $bits(tmr_ctrl_t);

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cur_count;
    logic             wr_load, wr_ctrl, wr_stat;
    logic             tick, fire, pre_clr, run;
    logic             bite, irq_q, rst_flag;
    logic             unused_bits;

    assign wr_load = bus_wr && (bus_addr == ADDR_LOAD);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
    assign unused_bits = ^bus_wdata[31:CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_load) load_q <= bus_wdata[CNT_W-1:0];
        end
    end

    mtw_prescaler #(.CODE_W(CODE_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pre_clr),
        .run   (run),
        .code  (ctrl_q.presc),
        .tick  (tick)
    );

    mtw_count_core #(.CNT_W(CNT_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctrl_q.enable),
        .mode     (ctrl_q.mode),
        .tick     (tick),
        .load_val (load_q),
        .load_wr  (wr_load),
        .wr_val   (bus_wdata[CNT_W-1:0]),
        .count    (cur_count),
        .fire     (fire),
        .pre_clr  (pre_clr),
        .run      (run)
    );

    assign bite = fire && (ctrl_q.mode == MODE_WDOG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= fire && (ctrl_q.mode != MODE_WDOG);
        end
    end

    mtw_reset_pulse #(.HOLD_CYC(HOLD_CYC)) i_rq (
        .clk        (clk),
        .por_n      (por_n),
        .bite       (bite),
        .flag_clr   (wr_stat && bus_wdata[CAUSE_BIT]),
        .req        (sys_rst_req),
        .cause_flag (rst_flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_LOAD: bus_rdata = 32'(cur_count);
                ADDR_CTRL: bus_rdata = 32'(ctrl_q);
                ADDR_STAT: bus_rdata = 32'(rst_flag) << CAUSE_BIT;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq_pulse = irq_q;
endmodule

// File: rtl/mtw_checker.sv
module mtw_checker #(
    parameter int CNT_W    = 16,
    parameter int HOLD_CYC = 16
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic [7:0]       ctrl_q,
    input logic [CNT_W-1:0] cur_count,
    input logic             irq_pulse,
    input logic             sys_rst_req,
    input logic             rst_flag
);
    localparam int HI_W = $clog2(HOLD_CYC + 2);

    logic [HI_W-1:0] hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hi_cnt <= '0;
        end else if (sys_rst_req) begin
            hi_cnt <= hi_cnt + HI_W'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_req_bound_R10: assert property (@(posedge clk) disable iff (!por_n)
        hi_cnt <= HI_W'(HOLD_CYC));

    assert_req_length_R10: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst_req) |-> (hi_cnt == HI_W'(HOLD_CYC)));

    assert_no_irq_wdog_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(ctrl_q[5:4]) != 2'd3));

    assert_flag_on_req_R11: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_req) |-> rst_flag);

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && $past(!ctrl_q[7])) |-> $stable(cur_count));

    assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_q[7]) |-> !irq_pulse);
endmodule

bind mode_timer_wdog mtw_checker #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) i_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .ctrl_q      (ctrl_q),
    .cur_count   (cur_count),
    .irq_pulse   (irq_pulse),
    .sys_rst_req (sys_rst_req),
    .rst_flag    (rst_flag)
);

// File: tb/test_mode_timer_wdog.sv
`timescale 1ns/1ps
module test_mode_timer_wdog;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;
    logic        sys_rst_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mode_timer_wdog i_mode_timer_wdog (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse), .sys_rst_req(sys_rst_req)
    );

    // Vector: [25:24] mode, [19:16] prescale code, [15:0] load value
    localparam int VEC_N = 8;
    localparam logic [31:0] VEC [VEC_N] = '{
        32'h0100_0005, 32'h0102_0003, 32'h0104_0001, 32'h0201_0000,
        32'h0203_0002, 32'h0000_0004, 32'h0001_0002, 32'h020F_0000
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin : watchdog_timer
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin : main
        logic [31:0] rd;
        logic [31:0] c1, c2;
        int k;
        bit seen;

        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h8, rd); check(rd == 0, "R1 ctrl", rd, 0);
        bus_read(4'h0, rd); check(rd == 0, "R1 count", rd, 0);
        bus_read(4'hC, rd); check(rd == 0, "R1 status", rd, 0);
        check(!irq_pulse && !sys_rst_req, "R1 outputs", {irq_pulse, sys_rst_req}, 0);

        // R2 control readback
        bus_write(4'h8, 32'hFFFF_FF4A);
        bus_read(4'h8, rd); check(rd == 32'h4A, "R2 readback", rd, 32'h4A);

        // Table walk: R3, R6, R7, R8
        for (int v = 0; v < VEC_N; v++) begin
            int mode, code, ld, per, expk, lim;
            mode = int'(VEC[v][25:24]);
            code = int'(VEC[v][19:16]);
            ld   = int'(VEC[v][15:0]);
            per  = (ld + 1) << ((code == 15) ? 16 : code);
            expk = 1 + per;
            bus_write(4'h8, 32'h0);
            bus_write(4'h0, 32'(ld));
            bus_write(4'h8, 32'(8'h80 | (mode << 4) | code));
            k = 0; seen = 0;
            while (!seen && k < expk + 8) begin
                @(negedge clk); k++;
                if (irq_pulse) seen = 1;
            end
            check(k == expk, "R3 first expiry", k, expk);
            if (mode == 0) begin
                bus_read(4'h0, rd); check(rd == 32'hFFFF, "R8 wrap", rd, 32'hFFFF);
            end
            @(negedge clk);
            check(!irq_pulse, "R6 pulse width", irq_pulse, 0);
            if (mode == 1) begin
                k = 1; seen = 0;
                while (!seen && k < per + 8) begin
                    @(negedge clk); k++;
                    if (irq_pulse) seen = 1;
                end
                check(k == per, "R6 period", k, per);
            end else if (mode == 2) begin
                bus_read(4'h0, rd); check(rd == 0, "R7 count stays 0", rd, 0);
                seen = 0;
                lim = (2 * per > 300) ? 300 : 2 * per;
                for (int i = 0; i < lim; i++) begin
                    @(negedge clk);
                    if (irq_pulse) seen = 1;
                end
                check(!seen, "R7 single pulse", seen, 0);
            end
        end

        // R4 hold while disabled, R5 arm load, R9 restart
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'd100);
        bus_write(4'h8, 32'h90);
        repeat (10) @(negedge clk);
        bus_write(4'h8, 32'h10);
        bus_read(4'h0, c1);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq_pulse || sys_rst_req) seen = 1;
        end
        bus_read(4'h0, c2);
        check(c1 == c2 && c1 < 100, "R4 hold", c2, c1);
        check(!seen, "R4 no events", seen, 0);
        bus_write(4'h0, 32'd5);
        bus_read(4'h0, rd); check(rd == c1, "R4 load write ignored", rd, c1);
        bus_write(4'h8, 32'h90);
        @(negedge clk);
        bus_read(4'h0, rd); check(rd == 5, "R5 arm load", rd, 5);
        bus_write(4'h0, 32'd2);
        k = 0; seen = 0;
        while (!seen && k < 20) begin
            @(negedge clk); k++;
            if (irq_pulse) seen = 1;
        end
        check(k == 3, "R9 restart", k, 3);

        // R10 watchdog keep-alive and expiry
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'd10);
        bus_write(4'h8, 32'hB0);
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            bus_write(4'h0, 32'd10);
            repeat (4) begin
                @(negedge clk);
                if (sys_rst_req || irq_pulse) seen = 1;
            end
        end
        check(!seen, "R9 keep-alive holds off expiry", seen, 0);
        bus_write(4'h0, 32'd10);
        k = 0; seen = 0;
        while (!sys_rst_req && k < 30) begin
            @(negedge clk); k++;
            if (irq_pulse) seen = 1;
        end
        check(k == 11, "R10 expiry time", k, 11);
        k = 0;
        while (sys_rst_req && k < 40) begin
            @(negedge clk); k++;
            if (irq_pulse) seen = 1;
        end
        check(k == 16, "R10 request length", k, 16);
        check(!seen, "R10 no irq", seen, 0);

        // R11 cause flag
        bus_read(4'hC, rd); check(rd == 2, "R11 flag set", rd, 2);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(4'h8, rd); check(rd == 0, "R1 ctrl after system reset", rd, 0);
        bus_read(4'hC, rd); check(rd == 2, "R11 flag survives", rd, 2);
        bus_write(4'hC, 32'h0);
        bus_read(4'hC, rd); check(rd == 2, "R11 write 0 no effect", rd, 2);
        bus_write(4'hC, 32'h2);
        bus_read(4'hC, rd); check(rd == 0, "R11 write 1 clears", rd, 0);

        finish_run();
    end
endmodule